// File: doc/BRIEF.md
# Boot Strap Decoder and Boot Sequencer

This block runs once per power cycle, straight after reset. It reads four strap voltages through a shared low-speed ADC, one conversion at a time, in this order: clock select, boot select, output-channel select and mix-ratio select. It sorts each returned code into one of eight presets and holds the result until the next reset. The latched presets are the chip's fixed configuration for the whole session.

When all four presets are latched, the boot-select preset decides how the chip starts. It can launch the on-chip application in one of three noise-reduction talk ranges, in a 1 kHz tone diagnostic, or in a plain input-to-output copy. It can also go to external boot. External boot asks a SPI EEPROM loader first and an I2C EEPROM loader second. If both fail, it waits for a host on I2C to download an application. A cycle timeout bounds each loader attempt, and a timeout counts as a failure.

Top module: `boot_strap_ctrl`

## Requirements
- R1: A code c from an ADC_W-bit converter (full scale 1 V) maps to a 3-bit preset. The code is compared with the gap midpoints 640, 495, 355, 215 and 75 mV, rounded up to whole codes; at ADC_W=10 these are 656, 507, 364, 221 and 77. Codes at or above 656 give preset 0 (the merged top band). Codes from 507 to 655 give 3, from 364 to 506 give 4, from 221 to 363 give 5, from 77 to 220 give 6, and codes below 77 give 7.
- R2: Conversions are requested one at a time on ADC channels 0 (clock), 1 (boot), 2 (channel select) and 3 (mix), in that order. adc_req_o and adc_ch_o hold until adc_valid_i is seen. cfg_valid_o rises in the cycle after the fourth code is accepted.
- R3: Once cfg_valid_o is high, adc_valid_i is ignored, adc_req_o stays low, and all four preset outputs stay unchanged until reset.
- R4: Boot presets 3, 4 and 5 raise app_run_o one cycle after cfg_valid_o. They set app_mode_o to 1 (50–500 cm), 2 (5–500 cm) and 3 (5–100 cm) respectively.
- R5: Boot preset 6 starts app_mode_o 4 (1 kHz tone at −12 dBFS on both outputs). Boot preset 7 starts app_mode_o 5 (passthrough).
- R6: Boot preset 0 raises spi_req_o one cycle after cfg_valid_o. spi_done_i then starts app_run_o with app_mode_o 6 (loaded application).
- R7: A SPI failure or timeout drops spi_req_o and raises i2c_req_o in the next cycle. i2c_done_i then starts app_mode_o 6.
- R8: An I2C failure or timeout raises host_wait_o. host_wait_o then stays high, and later loader responses are ignored.
- R9: A loader request with no response stays high for exactly TIMEOUT_CYC cycles.
- R10: int_osc_o is high exactly when the latched clock preset is 7. Presets 0, 3, 4, 5 and 6 expect external clocks of 2.048, 2.4, 2.8, 3.072 and 26 MHz.
- R11: After reset, adc_req_o is high on channel 0, and cfg_valid_o, spi_req_o, i2c_req_o, host_wait_o and app_run_o are low. At most one of the last four is ever high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| adc_req_o | output | 1 | Conversion request |
| adc_ch_o | output | 2 | Strap channel to convert |
| adc_valid_i | input | 1 | Conversion result valid |
| adc_code_i | input | ADC_W | Conversion result |
| spi_req_o | output | 1 | SPI EEPROM load attempt active |
| spi_done_i | input | 1 | SPI load succeeded |
| spi_fail_i | input | 1 | SPI load failed |
| i2c_req_o | output | 1 | I2C EEPROM load attempt active |
| i2c_done_i | input | 1 | I2C load succeeded |
| i2c_fail_i | input | 1 | I2C load failed |
| host_wait_o | output | 1 | Waiting for host download |
| app_run_o | output | 1 | Application started |
| app_mode_o | output | 3 | Started mode code |
| cfg_valid_o | output | 1 | All four presets latched |
| clk_preset_o | output | 3 | Clock preset |
| boot_preset_o | output | 3 | Boot preset |
| chan_preset_o | output | 3 | Output-channel preset |
| mix_preset_o | output | 3 | Mix-ratio preset |
| int_osc_o | output | 1 | Internal oscillator selected |

## Verification
The bench builds the block with the default ADC_W=10, which makes it practical to drive every one of the 1024 codes through the quantiser. Each boot feeds four consecutive codes, so every code is converted on one of the four channels. TIMEOUT_CYC is set to 8 so that both loader timeouts, the full fallback to host wait, and the exact length of the request window can be reached in a few cycles.

// File: rtl/boot_strap_pkg.sv
package boot_strap_pkg;
  typedef logic [2:0] preset_t;

  typedef enum logic [2:0] {
    MODE_NONE      = 3'd0,
    MODE_NR_MID    = 3'd1,
    MODE_NR_WIDE   = 3'd2,
    MODE_NR_CLOSE  = 3'd3,
    MODE_TONE      = 3'd4,
    MODE_PASS      = 3'd5,
    MODE_CUSTOM    = 3'd6
  } app_mode_e;

  localparam int NUM_STRAPS = 4;
  localparam int NUM_EDGES  = 5;

  // smallest code whose voltage reaches mv, full scale 1000 mV
  function automatic int unsigned edge_code(int unsigned mv, int unsigned w);
    return (mv * (32'd1 << w) + 32'd999) / 32'd1000;
  endfunction
endpackage

// File: rtl/strap_quantizer.sv
module strap_quantizer
  import boot_strap_pkg::*;
#(
  parameter int ADC_W = 10
) (
  input  logic [ADC_W-1:0] code_i,
  output preset_t          preset_o
);
  localparam int unsigned GAP_MV [NUM_EDGES] = '{640, 495, 355, 215, 75};

  logic [NUM_EDGES-1:0] above;

  for (genvar k = 0; k < NUM_EDGES; k++) begin : g_edge
    localparam int unsigned EDGE = edge_code(GAP_MV[k], ADC_W);
    assign above[k] = 32'(code_i) >= EDGE;
  end

  always_comb begin
    preset_o = 3'd7;
    for (int k = NUM_EDGES - 1; k >= 0; k--) begin
      if (above[k]) preset_o = (k == 0) ? 3'd0 : 3'(k + 2);
    end
  end
endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
  import boot_strap_pkg::*;
#(
  parameter int ADC_W = 10,
  parameter int NUM   = NUM_STRAPS,
  localparam int IDX_W = $clog2(NUM)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  output logic                  adc_req_o,
  output logic [IDX_W-1:0]      adc_ch_o,
  input  logic                  adc_valid_i,
  input  logic [ADC_W-1:0]      adc_code_i,
  output logic                  cfg_valid_o,
  output logic [NUM-1:0][2:0]   preset_o
);
  logic             busy_q;
  logic [IDX_W-1:0] idx_q;
  preset_t          q_preset;
  logic             take, last;

  strap_quantizer #(.ADC_W(ADC_W)) u_quant (
    .code_i  (adc_code_i),
    .preset_o(q_preset)
  );

  assign take = busy_q && adc_valid_i;
  assign last = idx_q == IDX_W'(NUM - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (take) begin
      if (last) busy_q <= 1'b0;
      else      idx_q  <= idx_q + 1'b1;
    end
  end

  for (genvar k = 0; k < NUM; k++) begin : g_latch
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                          preset_o[k] <= '0;
      else if (take && idx_q == IDX_W'(k)) preset_o[k] <= q_preset;
    end
  end

  assign adc_req_o   = busy_q;
  assign adc_ch_o    = idx_q;
  assign cfg_valid_o = !busy_q;

  assert_req_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_req_o && !adc_valid_i |=> adc_req_o && $stable(adc_ch_o));
  assert_frozen_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_valid_o |=> cfg_valid_o && $stable(preset_o));
  assert_order_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adc_req_o && adc_valid_i && adc_ch_o != IDX_W'(NUM - 1)
      |=> adc_ch_o == $past(adc_ch_o) + 1'b1);
endmodule

// File: rtl/boot_sequencer.sv
module boot_sequencer
  import boot_strap_pkg::*;
#(
  parameter int TIMEOUT_CYC = 1000,
  localparam int TMR_W = $clog2(TIMEOUT_CYC + 1)
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cfg_valid_i,
  input  preset_t    boot_preset_i,
  input  logic       spi_done_i,
  input  logic       spi_fail_i,
  input  logic       i2c_done_i,
  input  logic       i2c_fail_i,
  output logic       spi_req_o,
  output logic       i2c_req_o,
  output logic       host_wait_o,
  output logic       app_run_o,
  output logic [2:0] app_mode_o
);
  typedef enum logic [2:0] {SQ_IDLE, SQ_SPI, SQ_I2C, SQ_HOST, SQ_RUN} sq_e;

  sq_e        st_q;
  app_mode_e  mode_q;
  logic [TMR_W-1:0] tmr_q;
  logic       expired;

  assign expired = tmr_q == TMR_W'(TIMEOUT_CYC - 1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= SQ_IDLE;
      mode_q <= MODE_NONE;
      tmr_q  <= '0;
    end else begin
      unique case (st_q)
        SQ_IDLE: if (cfg_valid_i) begin
          tmr_q <= '0;
          st_q  <= SQ_RUN;
          unique case (boot_preset_i)
            3'd3:    mode_q <= MODE_NR_MID;
            3'd4:    mode_q <= MODE_NR_WIDE;
            3'd5:    mode_q <= MODE_NR_CLOSE;
            3'd6:    mode_q <= MODE_TONE;
            3'd7:    mode_q <= MODE_PASS;
            default: st_q   <= SQ_SPI;
          endcase
        end
        SQ_SPI: begin
          if (spi_done_i) begin
            st_q   <= SQ_RUN;
            mode_q <= MODE_CUSTOM;
          end else if (spi_fail_i || expired) begin
            st_q  <= SQ_I2C;
            tmr_q <= '0;
          end else tmr_q <= tmr_q + 1'b1;
        end
        SQ_I2C: begin
          if (i2c_done_i) begin
            st_q   <= SQ_RUN;
            mode_q <= MODE_CUSTOM;
          end else if (i2c_fail_i || expired) begin
            st_q  <= SQ_HOST;
            tmr_q <= '0;
          end else tmr_q <= tmr_q + 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign spi_req_o   = st_q == SQ_SPI;
  assign i2c_req_o   = st_q == SQ_I2C;
  assign host_wait_o = st_q == SQ_HOST;
  assign app_run_o   = st_q == SQ_RUN;
  assign app_mode_o  = mode_q;

  assert_one_owner_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({spi_req_o, i2c_req_o, host_wait_o, app_run_o}));
  assert_tmr_bound_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    32'(tmr_q) < TIMEOUT_CYC);
  assert_run_sticky_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    app_run_o |=> app_run_o && $stable(app_mode_o));
  assert_fallback_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(spi_req_o) |-> i2c_req_o || app_run_o);
  assert_host_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    host_wait_o |=> host_wait_o);
endmodule

// File: rtl/boot_strap_ctrl.sv
module boot_strap_ctrl
  import boot_strap_pkg::*;
#(
  parameter int ADC_W       = 10,
  parameter int TIMEOUT_CYC = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic             adc_req_o,
  output logic [1:0]       adc_ch_o,
  input  logic             adc_valid_i,
  input  logic [ADC_W-1:0] adc_code_i,
  output logic             spi_req_o,
  input  logic             spi_done_i,
  input  logic             spi_fail_i,
  output logic             i2c_req_o,
  input  logic             i2c_done_i,
  input  logic             i2c_fail_i,
  output logic             host_wait_o,
  output logic             app_run_o,
  output logic [2:0]       app_mode_o,
  output logic             cfg_valid_o,
  output logic [2:0]       clk_preset_o,
  output logic [2:0]       boot_preset_o,
  output logic [2:0]       chan_preset_o,
  output logic [2:0]       mix_preset_o,
  output logic             int_osc_o
);
  logic [NUM_STRAPS-1:0][2:0] presets;

  strap_sampler #(.ADC_W(ADC_W), .NUM(NUM_STRAPS)) u_sampler (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .adc_req_o  (adc_req_o),
    .adc_ch_o   (adc_ch_o),
    .adc_valid_i(adc_valid_i),
    .adc_code_i (adc_code_i),
    .cfg_valid_o(cfg_valid_o),
    .preset_o   (presets)
  );

  boot_sequencer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cfg_valid_i  (cfg_valid_o),
    .boot_preset_i(presets[1]),
    .spi_done_i   (spi_done_i),
    .spi_fail_i   (spi_fail_i),
    .i2c_done_i   (i2c_done_i),
    .i2c_fail_i   (i2c_fail_i),
    .spi_req_o    (spi_req_o),
    .i2c_req_o    (i2c_req_o),
    .host_wait_o  (host_wait_o),
    .app_run_o    (app_run_o),
    .app_mode_o   (app_mode_o)
  );

  assign clk_preset_o  = presets[0];
  assign boot_preset_o = presets[1];
  assign chan_preset_o = presets[2];
  assign mix_preset_o  = presets[3];
  assign int_osc_o     = cfg_valid_o && presets[0] == 3'd7;

  assert_start_after_cfg_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (spi_req_o || app_run_o) |-> cfg_valid_o);
  assert_osc_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_osc_o |-> clk_preset_o == 3'd7);
endmodule

// File: tb/boot_strap_ctrl_test.sv
module boot_strap_ctrl_test;
  localparam int ADC_W = 10;
  localparam int TMO   = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic adc_req_o, adc_valid_i = 1'b0;
  logic [1:0] adc_ch_o;
  logic [ADC_W-1:0] adc_code_i = '0;
  logic spi_req_o, spi_done_i = 1'b0, spi_fail_i = 1'b0;
  logic i2c_req_o, i2c_done_i = 1'b0, i2c_fail_i = 1'b0;
  logic host_wait_o, app_run_o, cfg_valid_o, int_osc_o;
  logic [2:0] app_mode_o, clk_preset_o, boot_preset_o, chan_preset_o, mix_preset_o;

  int errors = 0, checks = 0;
  bit finished = 0;

  always #2 clk_i = ~clk_i;

  boot_strap_ctrl #(.ADC_W(ADC_W), .TIMEOUT_CYC(TMO)) uut (.*);

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_preset(int c);
    if (c * 1000 >= 640 * 1024) return 0;
    if (c * 1000 >= 495 * 1024) return 3;
    if (c * 1000 >= 355 * 1024) return 4;
    if (c * 1000 >= 215 * 1024) return 5;
    if (c * 1000 >= 75 * 1024)  return 6;
    return 7;
  endfunction

  function automatic int code_for(int p);
    case (p)
      3: return 580; 4: return 440; 5: return 300;
      6: return 150; 7: return 20; default: return 900;
    endcase
  endfunction

  task automatic do_reset();
    rst_ni = 1'b0; adc_valid_i = 0; spi_done_i = 0; spi_fail_i = 0;
    i2c_done_i = 0; i2c_fail_i = 0;
    @(negedge clk_i); @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
  endtask

  task automatic feed(int c0, int c1, int c2, int c3, bit verbose);
    int codes[4];
    codes = '{c0, c1, c2, c3};
    for (int ch = 0; ch < 4; ch++) begin
      @(negedge clk_i);  // one idle cycle: request must hold
      if (verbose) begin
        chk("R2 req held", int'(adc_req_o), 1);
        chk("R2 channel order", int'(adc_ch_o), ch);
      end
      adc_code_i  = ADC_W'(codes[ch]);
      adc_valid_i = 1'b1;
      @(negedge clk_i);
      adc_valid_i = 1'b0;
    end
    if (verbose) chk("R2 cfg valid after fourth", int'(cfg_valid_o), 1);
  endtask

  initial begin
    do_reset();
    chk("R11 reset req", int'(adc_req_o), 1);
    chk("R11 reset ch", int'(adc_ch_o), 0);
    chk("R11 reset cfg", int'(cfg_valid_o), 0);
    chk("R11 reset owners",
        int'({spi_req_o, i2c_req_o, host_wait_o, app_run_o}), 0);

    // R1 exhaustive code sweep, four codes per boot
    for (int b = 0; b < 256; b++) begin
      do_reset();
      feed(4*b, 4*b+1, 4*b+2, 4*b+3, b < 2);
      chk("R1 clk preset",  int'(clk_preset_o),  exp_preset(4*b));
      chk("R1 boot preset", int'(boot_preset_o), exp_preset(4*b+1));
      chk("R1 chan preset", int'(chan_preset_o), exp_preset(4*b+2));
      chk("R1 mix preset",  int'(mix_preset_o),  exp_preset(4*b+3));
    end

    // R4 R5 R10 R3: on-chip start modes
    for (int p = 3; p <= 7; p++) begin
      do_reset();
      feed(code_for(p), code_for(p), 440, 300, 1'b0);
      chk("R4 R5 not yet running", int'(app_run_o), 0);
      @(negedge clk_i);
      chk("R4 R5 app run", int'(app_run_o), 1);
      chk("R4 R5 mode", int'(app_mode_o), p - 2);
      chk("R10 int osc", int'(int_osc_o), p == 7 ? 1 : 0);
      chk("R6 no spi", int'(spi_req_o), 0);
      adc_code_i = ADC_W'(900); adc_valid_i = 1'b1;
      @(negedge clk_i);
      adc_valid_i = 1'b0;
      @(negedge clk_i);
      chk("R3 boot frozen", int'(boot_preset_o), p);
      chk("R3 clk frozen", int'(clk_preset_o), p);
      chk("R3 chan frozen", int'(chan_preset_o), 4);
      chk("R3 mix frozen", int'(mix_preset_o), 5);
      chk("R3 no req", int'(adc_req_o), 0);
      chk("R3 mode kept", int'(app_mode_o), p - 2);
    end

    // R6: SPI succeeds
    do_reset();
    feed(900, 900, 900, 900, 1'b0);
    chk("R10 ext clock", int'(int_osc_o), 0);
    @(negedge clk_i);
    chk("R6 spi req", int'(spi_req_o), 1);
    chk("R6 no i2c", int'(i2c_req_o), 0);
    spi_done_i = 1'b1;
    @(negedge clk_i);
    spi_done_i = 1'b0;
    chk("R6 run", int'(app_run_o), 1);
    chk("R6 custom mode", int'(app_mode_o), 6);
    chk("R6 spi dropped", int'(spi_req_o), 0);

    // R7: SPI fails, I2C succeeds
    do_reset();
    feed(900, 700, 900, 900, 1'b0);
    @(negedge clk_i);
    chk("R7 spi req", int'(spi_req_o), 1);
    spi_fail_i = 1'b1;
    @(negedge clk_i);
    spi_fail_i = 1'b0;
    chk("R7 i2c req", int'(i2c_req_o), 1);
    chk("R7 spi off", int'(spi_req_o), 0);
    @(negedge clk_i);
    i2c_done_i = 1'b1;
    @(negedge clk_i);
    i2c_done_i = 1'b0;
    chk("R7 run", int'(app_run_o), 1);
    chk("R7 custom mode", int'(app_mode_o), 6);

    // R9 R8: both time out
    do_reset();
    feed(900, 900, 900, 900, 1'b0);
    @(negedge clk_i);
    begin
      int n = 0;
      while (spi_req_o && n < 100) begin n++; @(negedge clk_i); end
      chk("R9 spi window", n, TMO);
      chk("R7 timeout to i2c", int'(i2c_req_o), 1);
      n = 0;
      while (i2c_req_o && n < 100) begin n++; @(negedge clk_i); end
      chk("R9 i2c window", n, TMO);
    end
    chk("R8 host wait", int'(host_wait_o), 1);
    i2c_done_i = 1'b1; spi_done_i = 1'b1;
    @(negedge clk_i);
    i2c_done_i = 1'b0; spi_done_i = 1'b0;
    repeat (10) @(negedge clk_i);
    chk("R8 host held", int'(host_wait_o), 1);
    chk("R8 not run", int'(app_run_o), 0);

    // R8: SPI times out, I2C fails
    do_reset();
    feed(20, 900, 900, 900, 1'b0);
    chk("R10 int osc ext boot", int'(int_osc_o), 1);
    repeat (TMO + 1) @(negedge clk_i);
    chk("R9 i2c after timeout", int'(i2c_req_o), 1);
    i2c_fail_i = 1'b1;
    @(negedge clk_i);
    i2c_fail_i = 1'b0;
    chk("R8 host after fail", int'(host_wait_o), 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule